// File: doc/BRIEF.md
# Bus condition timers

This block observes an already synchronized and filtered pair of serial bus lines (clock and data) and derives the bus state that a target needs before it may start its own traffic. It recognises START conditions (data falling while clock stays high) and STOP conditions (data rising while clock stays high), keeps a busy flag between them, and measures how long the bus has been quiet since the last STOP.

One saturating elapsed-time counter is cleared and started by each STOP. Three status flags (free, available, idle) each compare that counter with a threshold of their own. The thresholds are loaded through a small write port and are fully independent, so the flags can come up in any order. A START clears the three time-based flags and stops the count; a high-speed-mode input holds the counter and the flags in reset while it is high.

Top module: `bus_cond_timers`

## Requirements
- R1: After reset busy_o, free_o, avail_o and idle_o are all low.
- R2: A START (sda_i sampled high then low while scl_i is sampled high on both edges) drives busy_o high and free_o, avail_o, idle_o low from the clock edge that samples it.
- R3: A STOP (sda_i sampled low then high while scl_i is sampled high on both edges) drives busy_o low from the edge that samples it and restarts the count; a flag with threshold T is first high after the edge T+1 cycles after that edge.
- R4: The three thresholds act independently, so any one flag may assert while the other two stay low, including available alone or idle alone.
- R5: A flag that is high stays high until the next START or high-speed entry, even through a further STOP or a threshold raised above the count.
- R6: While hdr_mode_i is high the three flags are low from the next edge and no STOP arms the count; after it falls, a new STOP again leads to free_o asserting on schedule.
- R7: A write with thr_we_i high loads thr_wdata_i into the threshold chosen by thr_sel_i (0 free, 1 available, 2 idle); selector value 3 changes nothing; a new threshold is used from the next edge.
- R8: The reset thresholds are 8 cycles for free, 50 for available and 10000 for idle (200 us at 50 MHz).
- R9: Data line changes while scl_i is low are neither START nor STOP and leave all four outputs unchanged.
- R10: Until the first STOP after reset or after a START or high-speed exit, the three time-based flags stay low however long the lines are quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized clock line |
| sda_i | input | 1 | Synchronized data line |
| hdr_mode_i | input | 1 | High while the bus runs a high-speed mode; holds the timers in reset |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_sel_i | input | 2 | Threshold select: 0 free, 1 available, 2 idle, 3 none |
| thr_wdata_i | input | CNT_W | Threshold value in clock cycles |
| busy_o | output | 1 | Bus is between a START and a STOP |
| free_o | output | 1 | Quiet time since STOP reached the free threshold |
| avail_o | output | 1 | Quiet time since STOP reached the available threshold |
| idle_o | output | 1 | Quiet time since STOP reached the idle threshold |

## Verification
The assertions take for granted that both lines arrive glitch-free and synchronous, and that a line never changes twice between two samples, so a START and a STOP cannot coincide. The stimulus changes inputs only on the falling clock edge and moves at most one of scl_i and sda_i per cycle whenever the clock line is high, which keeps every condition the bench creates unambiguous. Clock-low data toggles are driven deliberately to show they are not mistaken for conditions.

// File: rtl/bct_pkg.sv
package bct_pkg;

    localparam int unsigned NUM_FLAGS = 3;

    typedef enum logic [1:0] {
        THR_FREE  = 2'd0,
        THR_AVAIL = 2'd1,
        THR_IDLE  = 2'd2,
        THR_NONE  = 2'd3
    } thr_sel_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

endpackage

// File: rtl/bct_line_cond.sv
module bct_line_cond
    import bct_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o
);

    line_t line_d, line_q;
    logic  clk_held;

    always_comb begin
        line_d.scl = scl_i;
        line_d.sda = sda_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            line_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            line_q <= line_d;
        end
    end

    // Condition only when the clock line is high on both samples.
    assign clk_held = scl_i & line_q.scl;
    assign start_o  = clk_held &  line_q.sda & ~sda_i;
    assign stop_o   = clk_held & ~line_q.sda &  sda_i;

endmodule

// File: rtl/bct_elapsed.sv
module bct_elapsed #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         restart_i,
    input  logic         hold_i,
    output logic [W-1:0] cnt_o,
    output logic         armed_o
);

    localparam logic [W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         armed;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else if (restart_i) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end else if (st_q.armed && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign armed_o = st_q.armed;

endmodule

// File: rtl/bct_thr_bank.sv
module bct_thr_bank
    import bct_pkg::*;
#(
    parameter int unsigned   W         = 32,
    parameter logic [W-1:0]  FREE_RST  = W'(8),
    parameter logic [W-1:0]  AVAIL_RST = W'(50),
    parameter logic [W-1:0]  IDLE_RST  = W'(10000)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 we_i,
    input  thr_sel_e             sel_i,
    input  logic [W-1:0]         wdata_i,
    input  logic [W-1:0]         elapsed_i,
    input  logic                 armed_i,
    input  logic                 clear_i,
    output logic [NUM_FLAGS-1:0] flags_o
);

    localparam logic [NUM_FLAGS-1:0][W-1:0] THR_RST = {IDLE_RST, AVAIL_RST, FREE_RST};

    typedef struct packed {
        logic [NUM_FLAGS-1:0][W-1:0] thr;
        logic [NUM_FLAGS-1:0]        flag;
    } bank_st_t;

    bank_st_t             st_d, st_q;
    logic [NUM_FLAGS-1:0] hit_w;
    logic [NUM_FLAGS-1:0] wsel_w;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_cmp
        assign hit_w[g]  = (elapsed_i >= st_q.thr[g]);
        assign wsel_w[g] = we_i && (sel_i == thr_sel_e'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            if (wsel_w[i]) begin
                st_d.thr[i] = wdata_i;
            end
            st_d.flag[i] = ~clear_i & armed_i & (st_q.flag[i] | hit_w[i]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.thr  <= THR_RST;
            st_q.flag <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flag;

endmodule

// File: rtl/bus_cond_timers.sv
module bus_cond_timers
    import bct_pkg::*;
#(
    parameter int unsigned         CNT_W     = 32,
    parameter logic [CNT_W-1:0]    FREE_RST  = CNT_W'(8),
    parameter logic [CNT_W-1:0]    AVAIL_RST = CNT_W'(50),
    parameter logic [CNT_W-1:0]    IDLE_RST  = CNT_W'(10000)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             hdr_mode_i,
    input  logic             thr_we_i,
    input  logic [1:0]       thr_sel_i,
    input  logic [CNT_W-1:0] thr_wdata_i,
    output logic             busy_o,
    output logic             free_o,
    output logic             avail_o,
    output logic             idle_o
);

    typedef struct packed {
        logic busy;
    } top_st_t;

    logic                 start_w;
    logic                 stop_w;
    logic [CNT_W-1:0]     elapsed_w;
    logic                 armed_w;
    logic [NUM_FLAGS-1:0] flags_w;
    top_st_t              st_d, st_q;

    bct_line_cond u_cond (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (start_w),
        .stop_o  (stop_w)
    );

    bct_elapsed #(.W(CNT_W)) u_elapsed (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (stop_w),
        .hold_i    (hdr_mode_i | start_w),
        .cnt_o     (elapsed_w),
        .armed_o   (armed_w)
    );

    bct_thr_bank #(
        .W         (CNT_W),
        .FREE_RST  (FREE_RST),
        .AVAIL_RST (AVAIL_RST),
        .IDLE_RST  (IDLE_RST)
    ) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (thr_we_i),
        .sel_i     (thr_sel_e'(thr_sel_i)),
        .wdata_i   (thr_wdata_i),
        .elapsed_i (elapsed_w),
        .armed_i   (armed_w),
        .clear_i   (hdr_mode_i | start_w),
        .flags_o   (flags_w)
    );

    always_comb begin
        st_d = st_q;
        if (start_w) begin
            st_d.busy = 1'b1;
        end else if (stop_w) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = st_q.busy;
    assign free_o  = flags_w[THR_FREE];
    assign avail_o = flags_w[THR_AVAIL];
    assign idle_o  = flags_w[THR_IDLE];

endmodule

// File: rtl/bct_checker.sv
module bct_checker #(
    parameter int unsigned W = 32
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         start,
    input logic         stop,
    input logic         hdr,
    input logic         busy,
    input logic [2:0]   flags,
    input logic [W-1:0] cnt,
    input logic         armed
);

    localparam logic [W-1:0] CNT_MAX = '1;

    a_r2_start_busy_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start |=> (busy && (flags == 3'b000)));

    a_r3_stop_drops_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop |=> !busy);

    a_r3_stop_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop && !hdr) |=> (armed && (cnt == '0)));

    a_r6_hdr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hdr |=> ((flags == 3'b000) && !armed));

    a_r5_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start && !hdr) |=> ((flags & $past(flags)) == $past(flags)));

    a_r10_unarmed_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !armed |=> (flags == 3'b000));

    a_r3_cnt_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cnt == CNT_MAX) && !stop && !start && !hdr) |=> (cnt == CNT_MAX));

endmodule

bind bus_cond_timers bct_checker #(.W(CNT_W)) chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start  (start_w),
    .stop   (stop_w),
    .hdr    (hdr_mode_i),
    .busy   (busy_o),
    .flags  (flags_w),
    .cnt    (elapsed_w),
    .armed  (armed_w)
);

// File: tb/bus_cond_timers_tb_top.sv
`timescale 1ns/1ps
module bus_cond_timers_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda = 1'b1;
    logic        hdr = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [31:0] wdata = '0;
    logic        busy, free_f, avail_f, idle_f;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    bus_cond_timers dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .scl_i       (scl),
        .sda_i       (sda),
        .hdr_mode_i  (hdr),
        .thr_we_i    (we),
        .thr_sel_i   (sel),
        .thr_wdata_i (wdata),
        .busy_o      (busy),
        .free_o      (free_f),
        .avail_o     (avail_f),
        .idle_o      (idle_f)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] flags();
        return {idle_f, avail_f, free_f};
    endfunction

    task automatic negs(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic prog(input logic [1:0] s, input logic [31:0] v);
        @(negedge clk); we = 1'b1; sel = s; wdata = v;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); scl = 1'b0; sda = 1'b0;
        @(negedge clk); scl = 1'b1;
        @(negedge clk); sda = 1'b1;
    endtask

    task automatic do_start();
        @(negedge clk); scl = 1'b1; sda = 1'b1;
        @(negedge clk); sda = 1'b0;
    endtask

    // Per-cycle check after a STOP: flag with threshold T is high from step T+2.
    task automatic win(input string req, input int tf, input int ta, input int ti, input int len);
        for (int j = 1; j <= len; j++) begin
            @(negedge clk);
            if (j == 1) chk({req, " R3 busy after stop"}, busy, 0);
            chk({req, " free"},  free_f,  (j >= tf + 2));
            chk({req, " avail"}, avail_f, (j >= ta + 2));
            chk({req, " idle"},  idle_f,  (j >= ti + 2));
        end
    endtask

    task automatic run_window(input string req, input int tf, input int ta, input int ti, input int len);
        prog(2'd0, tf); prog(2'd1, ta); prog(2'd2, ti);
        do_start();
        do_stop();
        win(req, tf, ta, ti, len);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 flags", flags(), 0);
        negs(300);
        chk("R10 no flags before first stop", flags(), 0);
    endtask

    task automatic t_default_idle();
        do_stop();
        negs(9);
        chk("R8 free default", free_f, 0);
        negs(1);
        chk("R8 free default", free_f, 1);
        negs(10001 - 10);
        chk("R8 idle default low", idle_f, 0);
        chk("R8 avail default", avail_f, 1);
        negs(1);
        chk("R8 idle default high", idle_f, 1);
        do_start();
        @(negedge clk);
        chk("R2 busy on start", busy, 1);
        chk("R2 flags cleared", flags(), 0);
    endtask

    task automatic t_data_toggle();
        run_window("R9 setup", 2, 3, 4, 8);
        @(negedge clk); scl = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); sda = ~sda;
            @(negedge clk);
            chk("R9 busy unchanged", busy, 0);
            chk("R9 flags unchanged", flags(), 3'b111);
        end
        @(negedge clk); sda = 1'b1;
        @(negedge clk); scl = 1'b1;
        @(negedge clk);
        chk("R9 flags after clock rise", flags(), 3'b111);
    endtask

    task automatic t_sticky();
        prog(2'd0, 1000);
        @(negedge clk);
        chk("R5 free kept after raise", free_f, 1);
        do_stop();
        negs(3);
        chk("R5 flags kept through stop", flags(), 3'b111);
    endtask

    task automatic t_write();
        do_start();
        do_stop();
        negs(20);
        chk("R7 free still low", free_f, 0);
        @(negedge clk); we = 1'b1; sel = 2'd0; wdata = 10;
        @(negedge clk); we = 1'b0;
        chk("R7 not yet used", free_f, 0);
        @(negedge clk);
        chk("R7 new threshold used", free_f, 1);
        prog(2'd0, 6); prog(2'd1, 30); prog(2'd2, 30);
        prog(2'd3, 0);
        do_start();
        do_stop();
        win("R7 select 3 ignored", 6, 30, 30, 34);
    endtask

    task automatic t_hdr();
        run_window("R6 setup", 2, 2, 2, 6);
        @(negedge clk); hdr = 1'b1;
        @(negedge clk);
        chk("R6 flags cleared", flags(), 0);
        do_stop();
        negs(20);
        chk("R6 stop ignored in hdr", flags(), 0);
        @(negedge clk); hdr = 1'b0;
        negs(20);
        chk("R10 no flags after hdr exit", flags(), 0);
        do_stop();
        win("R6 free after hdr exit", 2, 2, 2, 6);
    endtask

    initial begin
        negs(3);
        rst_n = 1'b1;
        t_reset();
        t_default_idle();
        run_window("R3 exact", 5, 9, 12, 16);
        run_window("R4 avail only", 20, 3, 40, 10);
        run_window("R4 idle only", 40, 40, 3, 10);
        t_data_toggle();
        t_sticky();
        t_write();
        t_hdr();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule